// File: doc/BRIEF.md
# I2C Slave Byte Receiver with Clock Stretch Holds

This block is the receive side of an I2C target. It watches oversampled SCL and SDA lines on the system clock, passes them through a synchronizer, and finds Start, Repeated Start and Stop conditions. After a Start it shifts in an address byte MSB first. If the upper seven bits equal `own_addr` and the direction bit is 0 (write), the block acknowledges. Each later byte is shifted in, placed in a one-entry receive buffer, and acknowledged. The ACK is driven on SDA only after a selectable hold delay following the falling SCL edge.

Firmware can ask the block to stretch SCL low after the eighth bit of a matching address byte, of a data byte, or of both. The stretch ends when firmware pulses a release strobe. While either stretch option is enabled, an acknowledge-phase flag marks the window between the eighth falling SCL edge and the ninth rising one. A full/overflow pair of flags guards the buffer, and an overwrite option changes when a byte may enter it. Optional collision detection watches the acknowledge slot whenever the block leaves SDA high. If another device pulls SDA low in that slot, the block raises an interrupt and returns to idle.

The controller has six states:
- `ST_IDLE`: waiting for a Start.
- `ST_ADDR`: shifting in the address byte.
- `ST_ADDR_ACK`: the ninth clock after a matching address.
- `ST_DATA`: shifting in a data byte.
- `ST_DATA_ACK`: the ninth clock after a data byte.
- `ST_IGNORE`: the transfer is not for this block.

The transitions are:
- Start (from any state) goes to `ST_ADDR`.
- Stop (from any state) goes to `ST_IDLE`.
- A collision goes to `ST_IDLE`.
- In `ST_ADDR`, the eighth falling edge goes to `ST_ADDR_ACK` on a match and to `ST_IGNORE` otherwise.
- In `ST_ADDR_ACK`, the ninth falling edge goes to `ST_DATA` if the address was acknowledged and to `ST_IGNORE` if it was not.
- In `ST_DATA`, the eighth falling edge goes to `ST_DATA_ACK`.
- In `ST_DATA_ACK`, the ninth falling edge goes back to `ST_DATA`.

Top module: `i2c_hold_rx`

## Requirements
- R1: A falling SDA while SCL is high (Start or Repeated Start) restarts address reception from any state. It gives a one-cycle `start_irq` pulse when `start_ie` is 1 and no pulse when it is 0.
- R2: A rising SDA while SCL is high (Stop) returns the block to idle. It gives a one-cycle `stop_irq` pulse when `stop_ie` is 1 and no pulse when it is 0.
- R3: An address byte whose bits [7:1] equal `own_addr` and whose bit 0 is 0 is acknowledged (SDA driven low in the ninth clock). Any other address byte gets no ACK, and the data bytes that follow it get no ACK and do not change the buffer.
- R4: An accepted byte (the address byte included) is placed in `rx_data` MSB first, sets `buf_full`, and is acknowledged. A pulse on `rd_stb` clears `buf_full`.
- R5: A byte that completes while `buf_full` is 1 sets `ovf`, receives no ACK and leaves `rx_data` unchanged.
- R6: With `ovw_en` at 0, no byte is taken while `ovf` is 1, even into an empty buffer. With `ovw_en` at 1, a byte is taken and acknowledged whenever `buf_full` is 0, whatever `ovf` is. `ovf_clr` clears `ovf`.
- R7: With `addr_hold_en` at 1, a matching address byte clears `clk_rel` at its eighth falling SCL edge, and `scl_oe` holds SCL low until `release_stb` is pulsed. A non-matching address is never held.
- R8: With `data_hold_en` at 1, a data byte is held in the same way. A data byte is not held when only `addr_hold_en` is set, and an address byte is not held when only `data_hold_en` is set.
- R9: `ack_time` rises at the eighth falling SCL edge of a byte addressed to this block and falls at the next rising SCL edge. It stays 0 when both hold enables are 0.
- R10: The ACK drive on `sda_oe` starts, and after the ninth falling edge stops, `HOLD_SHORT` system cycles after the SCL edge when `long_hold` is 0 and `HOLD_LONG` cycles after it when `long_hold` is 1.
- R11: With `coll_en` at 1, SDA found low on the ninth rising SCL edge while the block leaves SDA high (a NACK) gives a `coll_irq` pulse and returns the block to idle. With `coll_en` at 0 there is no pulse.
- R12: After reset the block releases both lines, clears `buf_full`, `ovf` and `ack_time`, and sets `clk_rel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low (stretch) |
| sda_oe | output | 1 | 1 pulls SDA low (ACK) |
| own_addr | input | ADDR_W | Target address of this block |
| addr_hold_en | input | 1 | Stretch after a matching address byte |
| data_hold_en | input | 1 | Stretch after a data byte |
| ovw_en | input | 1 | Buffer overwrite policy select |
| coll_en | input | 1 | Enable collision detection |
| long_hold | input | 1 | Select the long SDA hold delay |
| start_ie | input | 1 | Enable the Start/Repeated Start interrupt |
| stop_ie | input | 1 | Enable the Stop interrupt |
| release_stb | input | 1 | Pulse: end a clock stretch |
| rd_stb | input | 1 | Pulse: buffer read, clears buf_full |
| ovf_clr | input | 1 | Pulse: clear ovf |
| rx_data | output | ADDR_W+1 | Receive buffer |
| buf_full | output | 1 | Receive buffer holds an unread byte |
| ovf | output | 1 | A byte arrived while the buffer was full |
| clk_rel | output | 1 | 0 while SCL is being stretched |
| ack_time | output | 1 | Acknowledge-phase window flag |
| start_irq | output | 1 | Start/Repeated Start interrupt pulse |
| stop_irq | output | 1 | Stop interrupt pulse |
| coll_irq | output | 1 | Collision interrupt pulse |

## Verification
The table-driven part sends a matching write address, a read to the same address, and addresses that differ from `own_addr` in a single bit. Each is followed by a data byte. This separates a full seven-bit compare and the direction-bit check from a partial compare, and shows that a rejected transfer leaves the buffer alone. Directed sequences then leave the buffer unread, with and without overwrite, to separate the overflow path from the plain NACK path. Other sequences set each hold enable alone to show that the address hold and the data hold are chosen independently. The ACK delay is sampled between the short and the long hold counts. A NACK slot with SDA forced low is run with collision detection on and then off.

// File: rtl/i2c_hold_pkg.sv
package i2c_hold_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_IGNORE
    } rx_state_e;
endpackage

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
    logic scl_p, sda_p, scl_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_p  <= 1'b1;
            sda_p  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_in};
            sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_in};
            scl_p  <= scl_sh[SYNC_STAGES-1];
            sda_p  <= sda_sh[SYNC_STAGES-1];
        end
    end

    assign scl_s     = scl_sh[SYNC_STAGES-1];
    assign sda_s     = sda_sh[SYNC_STAGES-1];
    assign scl_rise  = scl_s && !scl_p;
    assign scl_fall  = !scl_s && scl_p;
    assign start_det = scl_s && scl_p && sda_p && !sda_s;
    assign stop_det  = scl_s && scl_p && !sda_p && sda_s;
endmodule

// File: rtl/i2c_sda_hold.sv
module i2c_sda_hold #(
    parameter int HOLD_SHORT = 10,
    parameter int HOLD_LONG  = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic trig,
    input  logic trig_val,
    input  logic long_sel,
    output logic drv
);
    localparam int MAXC = (HOLD_LONG > HOLD_SHORT) ? HOLD_LONG : HOLD_SHORT;
    localparam int CW   = $clog2(MAXC + 1);

    logic [CW-1:0] cnt;
    logic          busy, pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            busy <= 1'b0;
            pend <= 1'b0;
            drv  <= 1'b0;
        end else if (clr) begin
            busy <= 1'b0;
            drv  <= 1'b0;
        end else if (trig) begin
            cnt  <= long_sel ? CW'(HOLD_LONG - 1) : CW'(HOLD_SHORT - 1);
            pend <= trig_val;
            busy <= 1'b1;
        end else if (busy) begin
            if (cnt == '0) begin
                drv  <= pend;
                busy <= 1'b0;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end
endmodule

// File: rtl/i2c_hold_rx.sv
module i2c_hold_rx
    import i2c_hold_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 7,
    parameter int HOLD_SHORT  = 10,
    parameter int HOLD_LONG   = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_oe,
    output logic              sda_oe,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              addr_hold_en,
    input  logic              data_hold_en,
    input  logic              ovw_en,
    input  logic              coll_en,
    input  logic              long_hold,
    input  logic              start_ie,
    input  logic              stop_ie,
    input  logic              release_stb,
    input  logic              rd_stb,
    input  logic              ovf_clr,
    output logic [ADDR_W:0]   rx_data,
    output logic              buf_full,
    output logic              ovf,
    output logic              clk_rel,
    output logic              ack_time,
    output logic              start_irq,
    output logic              stop_irq,
    output logic              coll_irq
);
    localparam int BYTE_W = ADDR_W + 1;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    rx_state_e         state, nstate;
    logic [BYTE_W-1:0] shreg;
    logic [CNT_W-1:0]  bitcnt;
    logic              ack_q;
    logic sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic in_rx, in_ack, is_addr, byte_done, addr_hit, take, accept;
    logic want_hold, coll_hit, bus_clr, sda_drv;

    i2c_cond_detect #(.SYNC_STAGES(SYNC_STAGES)) u_det (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    assign in_rx     = (state == ST_ADDR) || (state == ST_DATA);
    assign in_ack    = (state == ST_ADDR_ACK) || (state == ST_DATA_ACK);
    assign is_addr   = (state == ST_ADDR);
    assign byte_done = in_rx && scl_fall && (bitcnt == CNT_W'(BYTE_W));
    assign addr_hit  = (shreg[BYTE_W-1:1] == own_addr) && !shreg[0];
    assign take      = byte_done && (!is_addr || addr_hit);
    assign accept    = !buf_full && (ovw_en || !ovf);
    assign want_hold = is_addr ? addr_hold_en : data_hold_en;
    assign coll_hit  = coll_en && in_ack && scl_rise && !sda_s && !sda_drv;
    assign bus_clr   = start_det || stop_det || coll_hit;

    i2c_sda_hold #(.HOLD_SHORT(HOLD_SHORT), .HOLD_LONG(HOLD_LONG)) u_hold (
        .clk(clk), .rst_n(rst_n), .clr(bus_clr),
        .trig(take || (in_ack && scl_fall)),
        .trig_val(take && accept),
        .long_sel(long_hold), .drv(sda_drv)
    );

    assign sda_oe = sda_drv;
    assign scl_oe = !clk_rel;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    // next state
    always_comb begin
        nstate = state;
        if (stop_det)       nstate = ST_IDLE;
        else if (start_det) nstate = ST_ADDR;
        else if (coll_hit)  nstate = ST_IDLE;
        else begin
            unique case (state)
                ST_IDLE:     nstate = ST_IDLE;
                ST_ADDR:     if (byte_done) nstate = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK: if (scl_fall)  nstate = ack_q ? ST_DATA : ST_IGNORE;
                ST_DATA:     if (byte_done) nstate = ST_DATA_ACK;
                ST_DATA_ACK: if (scl_fall)  nstate = ST_DATA;
                ST_IGNORE:   nstate = ST_IGNORE;
                default:     nstate = ST_IDLE;
            endcase
        end
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg     <= '0;
            bitcnt    <= '0;
            ack_q     <= 1'b0;
            rx_data   <= '0;
            buf_full  <= 1'b0;
            ovf       <= 1'b0;
            clk_rel   <= 1'b1;
            ack_time  <= 1'b0;
            start_irq <= 1'b0;
            stop_irq  <= 1'b0;
            coll_irq  <= 1'b0;
        end else begin
            start_irq <= 1'b0;
            stop_irq  <= 1'b0;
            coll_irq  <= 1'b0;
            if (rd_stb)      buf_full <= 1'b0;
            if (ovf_clr)     ovf <= 1'b0;
            if (release_stb) clk_rel <= 1'b1;
            if (in_rx && scl_rise) begin
                shreg  <= {shreg[BYTE_W-2:0], sda_s};
                bitcnt <= bitcnt + 1'b1;
            end
            if (in_ack && scl_fall) bitcnt <= '0;
            if (in_ack && scl_rise) ack_time <= 1'b0;
            if (take) begin
                ack_q    <= accept;
                ack_time <= addr_hold_en || data_hold_en;
                if (buf_full) ovf <= 1'b1;
                if (accept) begin
                    rx_data  <= shreg;
                    buf_full <= 1'b1;
                end
                if (want_hold) clk_rel <= 1'b0;
            end
            if (bus_clr) begin
                bitcnt    <= '0;
                ack_time  <= 1'b0;
                clk_rel   <= 1'b1;
                start_irq <= start_det && start_ie;
                stop_irq  <= stop_det && stop_ie;
                coll_irq  <= coll_hit && !start_det && !stop_det;
            end
        end
    end
endmodule

// File: rtl/i2c_hold_rx_chk.sv
module i2c_hold_rx_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_ie,
    input logic          stop_ie,
    input logic          coll_en,
    input logic          ahen,
    input logic          dhen,
    input logic          release_stb,
    input logic          scl_rise,
    input logic          scl_fall,
    input logic          start_det,
    input logic          stop_det,
    input logic          coll_hit,
    input logic          ack_time,
    input logic          clk_rel,
    input logic          buf_full,
    input logic          ovf,
    input logic [DW-1:0] rx_data,
    input logic          start_irq,
    input logic          stop_irq,
    input logic          coll_irq,
    input logic          state_idle
);
    assert_start_irq_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start_irq |-> $past(start_ie && start_det));
    assert_stop_irq_R2: assert property (@(posedge clk) disable iff (!rst_n)
        stop_irq |-> $past(stop_ie && stop_det));
    assert_irq_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_irq, stop_irq, coll_irq}));
    assert_ovf_when_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> $past(buf_full));
    assert_load_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_data) |-> $past(!buf_full));
    assert_hold_begin_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_rel) |-> $past(scl_fall && (ahen || dhen)));
    assert_hold_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_rel) |-> $past(release_stb || start_det || stop_det || coll_hit));
    assert_ack_time_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_time) |-> $past((ahen || dhen) && scl_fall));
    assert_ack_time_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_time) |-> $past(scl_rise || start_det || stop_det));
    assert_coll_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        coll_irq |-> (state_idle && $past(coll_en)));
endmodule

bind i2c_hold_rx i2c_hold_rx_chk #(.DW(ADDR_W + 1)) u_chk (
    .clk(clk), .rst_n(rst_n), .start_ie(start_ie), .stop_ie(stop_ie),
    .coll_en(coll_en), .ahen(addr_hold_en), .dhen(data_hold_en),
    .release_stb(release_stb), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .coll_hit(coll_hit),
    .ack_time(ack_time), .clk_rel(clk_rel), .buf_full(buf_full), .ovf(ovf),
    .rx_data(rx_data), .start_irq(start_irq), .stop_irq(stop_irq),
    .coll_irq(coll_irq), .state_idle(state == i2c_hold_pkg::ST_IDLE)
);

// File: tb/i2c_hold_rx_bench.sv
module i2c_hold_rx_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HP         = 50;
    localparam int HS         = 10;
    localparam int HL         = 30;
    localparam logic [6:0] OWN = 7'h3A;
    // {addr7, rw, data8, expected address ACK}
    localparam logic [16:0] VEC [6] = '{
        {7'h3A, 1'b0, 8'hA5, 1'b1},
        {7'h3B, 1'b0, 8'h11, 1'b0},
        {7'h3A, 1'b1, 8'h22, 1'b0},
        {7'h3A, 1'b0, 8'h5C, 1'b1},
        {7'h1A, 1'b0, 8'h33, 1'b0},
        {7'h7A, 1'b0, 8'h44, 1'b0}
    };

    logic clk = 0, rst_n = 0;
    logic scl_m = 1, sda_m = 1, sda_x = 0;
    logic scl_oe, sda_oe, buf_full, ovf, clk_rel, ack_time;
    logic start_irq, stop_irq, coll_irq;
    logic addr_hold_en = 0, data_hold_en = 0, ovw_en = 0, coll_en = 0, long_hold = 0;
    logic start_ie = 0, stop_ie = 0, release_stb = 0, rd_stb = 0, ovf_clr = 0;
    logic [7:0] rx_data;
    wire scl_line = scl_m & ~scl_oe;
    wire sda_line = sda_m & ~sda_oe & ~sda_x;
    int checks = 0, errors = 0, n_start = 0, n_stop = 0, n_coll = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_hold_rx #(.HOLD_SHORT(HS), .HOLD_LONG(HL)) u_i2c_hold_rx (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_line), .sda_in(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(OWN),
        .addr_hold_en(addr_hold_en), .data_hold_en(data_hold_en), .ovw_en(ovw_en),
        .coll_en(coll_en), .long_hold(long_hold), .start_ie(start_ie), .stop_ie(stop_ie),
        .release_stb(release_stb), .rd_stb(rd_stb), .ovf_clr(ovf_clr),
        .rx_data(rx_data), .buf_full(buf_full), .ovf(ovf), .clk_rel(clk_rel),
        .ack_time(ack_time), .start_irq(start_irq), .stop_irq(stop_irq), .coll_irq(coll_irq)
    );

    always @(posedge clk) begin
        if (start_irq) n_start++;
        if (stop_irq)  n_stop++;
        if (coll_irq)  n_coll++;
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic scl_up;
        scl_m = 1;
        cyc(1);
        while (!scl_line) cyc(1);
    endtask

    task automatic pulse(ref logic s);
        s = 1; cyc(1); s = 0; cyc(3);
    endtask

    task automatic bus_start;
        sda_m = 0; cyc(HP); scl_m = 0; cyc(HP);
    endtask

    task automatic bus_rstart;
        sda_m = 1; cyc(HP); scl_up; cyc(HP); sda_m = 0; cyc(HP); scl_m = 0; cyc(HP);
    endtask

    task automatic bus_stop;
        sda_m = 0; cyc(HP); scl_up; cyc(HP); sda_m = 1; cyc(HP);
    endtask

    task automatic send8(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; cyc(HP); scl_up; cyc(HP); scl_m = 0;
            if (i != 0) cyc(HP);
        end
        cyc(1);
    endtask

    task automatic ack9(output logic a);
        sda_m = 1; cyc(2); scl_up; cyc(HP/2);
        a = !sda_line;
        cyc(HP/2); scl_m = 0; cyc(HP);
    endtask

    task automatic xfer(input logic [7:0] b, output logic a);
        send8(b); cyc(HP); ack9(a);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic a;
        cyc(5);
        // R12 reset state
        chk("R12 scl_oe", scl_oe, 0);
        chk("R12 sda_oe", sda_oe, 0);
        chk("R12 buf_full", buf_full, 0);
        chk("R12 ovf", ovf, 0);
        chk("R12 clk_rel", clk_rel, 1);
        chk("R12 ack_time", ack_time, 0);
        rst_n = 1; cyc(5);

        // R3 R4 table walk
        foreach (VEC[k]) begin
            bus_start;
            xfer(VEC[k][16:9], a);
            chk("R3 address ack", a, VEC[k][0]);
            if (VEC[k][0]) begin
                chk("R4 address in buffer", rx_data, VEC[k][16:9]);
                chk("R4 full after address", buf_full, 1);
                pulse(rd_stb);
                chk("R4 rd_stb clears full", buf_full, 0);
                xfer(VEC[k][8:1], a);
                chk("R4 data ack", a, 1);
                chk("R4 data value", rx_data, VEC[k][8:1]);
                pulse(rd_stb);
            end else begin
                xfer(VEC[k][8:1], a);
                chk("R3 ignored data no ack", a, 0);
                chk("R3 ignored data buffer", buf_full, 0);
            end
            bus_stop;
        end

        // R5 overflow, R6 overwrite policy
        bus_start;
        xfer(8'h74, a);
        xfer(8'h55, a);
        chk("R5 nack when full", a, 0);
        chk("R5 ovf set", ovf, 1);
        chk("R5 rx_data kept", rx_data, 8'h74);
        pulse(rd_stb);
        xfer(8'h66, a);
        chk("R6 no load while ovf", a, 0);
        chk("R6 buffer still empty", buf_full, 0);
        ovw_en = 1;
        xfer(8'h77, a);
        chk("R6 overwrite ack", a, 1);
        chk("R6 overwrite value", rx_data, 8'h77);
        pulse(ovf_clr);
        chk("R6 ovf_clr", ovf, 0);
        pulse(rd_stb);
        ovw_en = 0;
        bus_stop;

        // R1 R2 interrupts
        start_ie = 1; stop_ie = 1;
        bus_start;
        xfer(8'h74, a);
        pulse(rd_stb);
        bus_rstart;
        xfer(8'h74, a);
        chk("R1 ack after repeated start", a, 1);
        pulse(rd_stb);
        bus_stop;
        chk("R1 start pulses", n_start, 2);
        chk("R2 stop pulses", n_stop, 1);
        start_ie = 0; stop_ie = 0;
        bus_start; bus_stop;
        chk("R1 no start pulse when disabled", n_start, 2);
        chk("R2 no stop pulse when disabled", n_stop, 1);

        // R7 R9 address hold
        addr_hold_en = 1;
        bus_start;
        send8(8'h74); cyc(HP);
        chk("R7 scl held", scl_oe, 1);
        chk("R7 clk_rel low", clk_rel, 0);
        chk("R9 ack_time high", ack_time, 1);
        sda_m = 1; cyc(2); scl_m = 1; cyc(20);
        chk("R7 line stays low", scl_line, 0);
        pulse(release_stb);
        chk("R7 released", scl_oe, 0);
        scl_up; cyc(HP);
        chk("R9 ack_time cleared", ack_time, 0);
        scl_m = 0; cyc(HP);
        pulse(rd_stb);
        send8(8'h21); cyc(HP);
        chk("R8 data not held by address hold", clk_rel, 1);
        ack9(a);
        pulse(rd_stb);
        bus_stop;
        bus_start;
        send8(8'h20); cyc(HP);
        chk("R7 mismatch not held", scl_oe, 0);
        chk("R9 mismatch no ack_time", ack_time, 0);
        ack9(a);
        bus_stop;
        addr_hold_en = 0;

        // R8 data hold
        data_hold_en = 1;
        bus_start;
        send8(8'h74); cyc(HP);
        chk("R8 address not held by data hold", clk_rel, 1);
        ack9(a);
        pulse(rd_stb);
        send8(8'hC3); cyc(HP);
        chk("R8 data held", clk_rel, 0);
        chk("R9 ack_time with data hold", ack_time, 1);
        pulse(release_stb);
        ack9(a);
        chk("R8 data ack", a, 1);
        chk("R8 data value", rx_data, 8'hC3);
        pulse(rd_stb);
        bus_stop;
        data_hold_en = 0;

        // R10 SDA hold delay, R9 no flag without enables
        for (int lh = 0; lh < 2; lh++) begin
            long_hold = lh[0];
            bus_start;
            send8(8'h74); cyc(20);
            chk("R10 ack drive at 20", sda_oe, lh == 0);
            chk("R9 ack_time off", ack_time, 0);
            cyc(30);
            chk("R10 ack drive at 50", sda_oe, 1);
            sda_m = 1; cyc(2); scl_up; cyc(HP); scl_m = 0; cyc(5);
            chk("R10 ack still held", sda_oe, 1);
            cyc(15);
            chk("R10 release at 20", sda_oe, lh != 0);
            cyc(30);
            chk("R10 release at 50", sda_oe, 0);
            pulse(rd_stb);
            bus_stop;
        end
        long_hold = 0;

        // R11 collision
        for (int ce = 0; ce < 2; ce++) begin
            coll_en = ce[0];
            bus_start;
            xfer(8'h74, a);
            send8(8'h99); cyc(HP);
            sda_x = 1;
            ack9(a);
            sda_x = 0;
            chk("R11 collision pulses", n_coll, ce);
            if (ce == 1) begin
                pulse(rd_stb);
                xfer(8'h12, a);
                chk("R11 idle after collision", a, 0);
                chk("R11 idle buffer empty", buf_full, 0);
            end
            pulse(rd_stb);
            pulse(ovf_clr);
            bus_stop;
        end

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule